// File: doc/BRIEF.md
# Nested Loop and Call Stacks

This block holds the three hardware stacks behind a small sequencer's program counter. The first stack keeps return addresses for subroutine calls. The other two stacks sit side by side: one holds loop start addresses and the other holds loop iteration counts. The instruction decoder drives four command strobes, for call, return, loop-begin and loop-end. Each strobe comes with the address of the instruction that follows the current one, and loop-begin also comes with a count. For every return and loop-end, the block reports in the same cycle whether the program counter must jump and, if so, to which address.

A loop-begin pushes the loop body's start address and its count in one cycle. At each loop-end the block looks at the count on top of its stack. A nonzero count is decremented in place and the loop branches back. A zero count pops both loop stacks and the loop falls through. A count loaded as N therefore runs the body N+1 times, and nested loops need no software counter. The call stack and the loop stacks are fully independent, so subroutines can be called inside loops and can hold loops of their own.

A push onto a full stack is dropped and raises a sticky overflow flag. A pop from an empty stack raises a sticky underflow flag. A synchronous reset empties every stack and clears both flags.

Top module: `loop_call_stack`

## Requirements
- R1: While `rst` is high at a clock edge, all three stacks are emptied and both error flags are cleared. After reset, `taken_o`, `overflow_o` and `underflow_o` read 0.
- R2: A call pushes `next_addr_i` onto the return stack. A return on a non-empty return stack pops it, drives `taken_o`=1 and puts the popped value on `target_o` in that same cycle, in last-in first-out order.
- R3: A call while the return stack already holds 16 entries, or a loop-begin while the loop stacks hold 16 entries, is dropped and sets `overflow_o` from the next cycle. The stored entries are unchanged.
- R4: A return on an empty return stack, or a loop-end on empty loop stacks, sets `underflow_o` from the next cycle. Such a command gives `taken_o`=0 and changes no stack.
- R5: A loop-begin pushes `next_addr_i` onto the loop-address stack and `loop_count_i` onto the loop-count stack. A loop-end whose top count is nonzero gives `taken_o`=1 and `target_o` equal to the top start address, and it decrements the top count by one.
- R6: A loop-end whose top count is zero pops both loop stacks and gives `taken_o`=0. A count of N yields exactly N taken loop-ends before the fall-through, and a count of 0 yields none.
- R7: Loops nest to the stack depth. When an inner loop falls through, the next loop-end acts on the outer loop's address and its remaining count.
- R8: Call/return and loop-begin/loop-end act independently in the same cycle. If a return and a loop-end are both taken in one cycle, `target_o` carries the return address, `taken_o`=1, and the loop count still steps.
- R9: If call and return are strobed together, only the call acts. If loop-begin and loop-end are strobed together, only the loop-begin acts.
- R10: Once set, `overflow_o` and `underflow_o` stay at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call strobe: push return address |
| ret_i | input | 1 | Return strobe: pop and jump |
| loop_begin_i | input | 1 | Loop-begin strobe: push start address and count |
| loop_end_i | input | 1 | Loop-end strobe: branch back or fall through |
| next_addr_i | input | AW (12) | Address of the instruction after the current one |
| loop_count_i | input | CW (12) | Loop count pushed at loop-begin |
| target_o | output | AW (12) | Branch target, valid while taken_o is 1 |
| taken_o | output | 1 | Program counter must load target_o |
| overflow_o | output | 1 | Sticky: a push was dropped on a full stack |
| underflow_o | output | 1 | Sticky: a pop was requested on an empty stack |

## Verification
Two functions can land in the same cycle: a return popping the call stack and a loop-end stepping the loop stacks. When both are taken, they compete for `target_o`. The random phase draws the four strobes independently, so these collisions occur often, and a directed case sets up a taken return and a taken loop-end together. Each cycle is judged against a bench model that keeps its own copies of the three stacks. The model confirms that the return address wins the target and that the loop count still steps, which a later loop-end then exposes at the ports.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    localparam int LCS_DEPTH = 16;
    localparam int LCS_AW    = 12;
    localparam int LCS_CW    = 12;

    // One stack operation per cycle; push has priority over pop over top rewrite.
    typedef struct packed {
        logic push;
        logic pop;
        logic wr_top;
    } stk_op_t;

    // Which stack supplies the branch target this cycle.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RET  = 2'd1,
        TGT_LOOP = 2'd2
    } tgt_src_e;

    function automatic stk_op_t stk_op_idle();
        stk_op_t op;
        op.push   = 1'b0;
        op.pop    = 1'b0;
        op.wr_top = 1'b0;
        return op;
    endfunction

    function automatic tgt_src_e pick_target(input logic ret_taken, input logic loop_taken);
        if (ret_taken)       return TGT_RET;
        else if (loop_taken) return TGT_LOOP;
        else                 return TGT_NONE;
    endfunction

endpackage

// File: rtl/lcs_stack.sv
module lcs_stack
    import lcs_pkg::*;
#(
    parameter int DEPTH = LCS_DEPTH,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  stk_op_t      op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top_data,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [PW:0]   fill;
    logic [PW-1:0] top_idx;
    logic [W-1:0]  mem [DEPTH];

    assign empty    = (fill == '0);
    assign full     = (fill == (PW+1)'(DEPTH));
    assign top_idx  = fill[PW-1:0] - 1'b1;
    assign top_data = mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else if (op.push) begin
            if (!full) fill <= fill + 1'b1;
        end else if (op.pop) begin
            if (!empty) fill <= fill - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (op.push) begin
                if (!full) mem[fill[PW-1:0]] <= wdata;
            end else if (op.wr_top && !op.pop && !empty) begin
                mem[top_idx] <= wdata;
            end
        end
    end

endmodule

// File: rtl/lcs_call_ctrl.sv
module lcs_call_ctrl
    import lcs_pkg::*;
(
    input  logic    call,
    input  logic    ret,
    input  logic    full,
    input  logic    empty,
    output stk_op_t op,
    output logic    taken,
    output logic    ovf_evt,
    output logic    unf_evt
);
    logic do_ret;

    // Call wins over a simultaneous return.
    assign do_ret = ret && !call;

    always_comb begin
        op      = stk_op_idle();
        op.push = call;
        op.pop  = do_ret;
    end

    assign taken   = do_ret && !empty;
    assign ovf_evt = call && full;
    assign unf_evt = do_ret && empty;

endmodule

// File: rtl/lcs_loop_ctrl.sv
module lcs_loop_ctrl
    import lcs_pkg::*;
#(
    parameter int CW = LCS_CW
) (
    input  logic          lp_begin,
    input  logic          lp_end,
    input  logic [CW-1:0] count_in,
    input  logic [CW-1:0] cnt_top,
    input  logic          empty,
    input  logic          full,
    output stk_op_t       addr_op,
    output stk_op_t       cnt_op,
    output logic [CW-1:0] cnt_wdata,
    output logic          taken,
    output logic          ovf_evt,
    output logic          unf_evt
);
    logic do_end;
    logic cnt_zero;

    // Loop-begin wins over a simultaneous loop-end.
    assign do_end   = lp_end && !lp_begin;
    assign cnt_zero = (cnt_top == '0);

    always_comb begin
        addr_op        = stk_op_idle();
        cnt_op         = stk_op_idle();
        addr_op.push   = lp_begin;
        cnt_op.push    = lp_begin;
        addr_op.pop    = do_end && cnt_zero;
        cnt_op.pop     = do_end && cnt_zero;
        cnt_op.wr_top  = do_end && !cnt_zero;
        cnt_wdata      = lp_begin ? count_in : (cnt_top - 1'b1);
    end

    assign taken   = do_end && !empty && !cnt_zero;
    assign ovf_evt = lp_begin && full;
    assign unf_evt = do_end && empty;

endmodule

// File: rtl/loop_call_stack.sv
module loop_call_stack
    import lcs_pkg::*;
#(
    parameter int DEPTH = LCS_DEPTH,
    parameter int AW    = LCS_AW,
    parameter int CW    = LCS_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          loop_begin_i,
    input  logic          loop_end_i,
    input  logic [AW-1:0] next_addr_i,
    input  logic [CW-1:0] loop_count_i,
    output logic [AW-1:0] target_o,
    output logic          taken_o,
    output logic          overflow_o,
    output logic          underflow_o
);
    stk_op_t       rs_op, la_op, lc_op;
    logic [AW-1:0] rs_top, addr_top;
    logic [CW-1:0] cnt_top, cnt_wdata;
    logic          rs_empty, rs_full;
    logic          ls_empty, ls_full;
    logic          lc_empty, lc_full;
    logic          rs_taken, ls_taken;
    logic          rs_ovf, rs_unf, ls_ovf, ls_unf;
    tgt_src_e      tsel;
    logic          ovf_q, unf_q;

    lcs_stack #(.DEPTH(DEPTH), .W(AW)) u_ret_stk (
        .clk(clk), .rst(rst), .op(rs_op), .wdata(next_addr_i),
        .top_data(rs_top), .empty(rs_empty), .full(rs_full)
    );

    lcs_stack #(.DEPTH(DEPTH), .W(AW)) u_addr_stk (
        .clk(clk), .rst(rst), .op(la_op), .wdata(next_addr_i),
        .top_data(addr_top), .empty(ls_empty), .full(ls_full)
    );

    lcs_stack #(.DEPTH(DEPTH), .W(CW)) u_cnt_stk (
        .clk(clk), .rst(rst), .op(lc_op), .wdata(cnt_wdata),
        .top_data(cnt_top), .empty(lc_empty), .full(lc_full)
    );

    lcs_call_ctrl u_call (
        .call(call_i), .ret(ret_i), .full(rs_full), .empty(rs_empty),
        .op(rs_op), .taken(rs_taken), .ovf_evt(rs_ovf), .unf_evt(rs_unf)
    );

    lcs_loop_ctrl #(.CW(CW)) u_loop (
        .lp_begin(loop_begin_i), .lp_end(loop_end_i), .count_in(loop_count_i),
        .cnt_top(cnt_top), .empty(ls_empty || lc_empty), .full(ls_full || lc_full),
        .addr_op(la_op), .cnt_op(lc_op), .cnt_wdata(cnt_wdata),
        .taken(ls_taken), .ovf_evt(ls_ovf), .unf_evt(ls_unf)
    );

    assign tsel = pick_target(rs_taken, ls_taken);

    always_comb begin
        case (tsel)
            TGT_RET:  target_o = rs_top;
            TGT_LOOP: target_o = addr_top;
            default:  target_o = '0;
        endcase
    end

    assign taken_o = (tsel != TGT_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (rs_ovf || ls_ovf) ovf_q <= 1'b1;
            if (rs_unf || ls_unf) unf_q <= 1'b1;
        end
    end

    assign overflow_o  = ovf_q;
    assign underflow_o = unf_q;

endmodule

// File: rtl/lcs_checker.sv
module lcs_checker #(
    parameter int AW = 12,
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          call_i,
    input logic          ret_i,
    input logic          loop_begin_i,
    input logic          loop_end_i,
    input logic [AW-1:0] target_o,
    input logic          taken_o,
    input logic          overflow_o,
    input logic          underflow_o,
    input logic          rs_empty,
    input logic          rs_full,
    input logic          ls_empty,
    input logic          ls_full,
    input logic [AW-1:0] rs_top,
    input logic [CW-1:0] cnt_top
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!overflow_o && !underflow_o));

    assert_ret_target_R2: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && !rs_empty) |-> (taken_o && target_o == rs_top));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        ((call_i && rs_full) || (loop_begin_i && ls_full)) |=> overflow_o);

    assert_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        ((ret_i && !call_i && rs_empty) || (loop_end_i && !loop_begin_i && ls_empty)) |=> underflow_o);

    assert_taken_source_R4: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> ((ret_i && !call_i && !rs_empty) || (loop_end_i && !loop_begin_i && !ls_empty)));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (loop_end_i && !loop_begin_i && !ls_empty && cnt_top != '0) |=> (cnt_top == $past(cnt_top) - CW'(1)));

    assert_fall_through_R6: assert property (@(posedge clk) disable iff (rst)
        (loop_end_i && !loop_begin_i && !ls_empty && cnt_top == '0 && !ret_i) |-> !taken_o);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> underflow_o);

endmodule

bind loop_call_stack lcs_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .loop_begin_i(loop_begin_i), .loop_end_i(loop_end_i),
    .target_o(target_o), .taken_o(taken_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o),
    .rs_empty(rs_empty), .rs_full(rs_full),
    .ls_empty(ls_empty), .ls_full(ls_full),
    .rs_top(rs_top), .cnt_top(cnt_top)
);

// File: tb/loop_call_stack_tb.sv
`timescale 1ns/1ps
module loop_call_stack_tb;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_i = 0, ret_i = 0, loop_begin_i = 0, loop_end_i = 0;
    logic [11:0] next_addr_i = '0, loop_count_i = '0;
    logic [11:0] target_o;
    logic        taken_o, overflow_o, underflow_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // bench model
    logic [11:0] m_rs [D];
    logic [11:0] m_la [D];
    logic [11:0] m_lc [D];
    int          m_rn, m_ln;
    bit          m_ovf, m_unf;
    int          taken_count;

    always #2 clk = ~clk;

    loop_call_stack u_dut (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .loop_begin_i(loop_begin_i), .loop_end_i(loop_end_i),
        .next_addr_i(next_addr_i), .loop_count_i(loop_count_i),
        .target_o(target_o), .taken_o(taken_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_taken_f(input bit c, input bit r, input bit b, input bit e);
        bit rt = r && !c && m_rn > 0;
        bit lt = e && !b && m_ln > 0 && m_lc[m_ln-1] != 0;
        return rt || lt;
    endfunction

    function automatic logic [11:0] exp_target_f(input bit c, input bit r);
        if (r && !c && m_rn > 0) return m_rs[m_rn-1];
        return m_la[m_ln-1];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; call_i = 0; ret_i = 0; loop_begin_i = 0; loop_end_i = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_rn = 0; m_ln = 0; m_ovf = 0; m_unf = 0;
        #1;
        chk(overflow_o == 1'b0, "R1", "overflow after reset", overflow_o, 0);
        chk(underflow_o == 1'b0, "R1", "underflow after reset", underflow_o, 0);
        chk(taken_o == 1'b0, "R1", "taken after reset", taken_o, 0);
    endtask

    task automatic cyc(input bit c, input bit r, input bit b, input bit e,
                       input logic [11:0] na, input logic [11:0] cn, input string tag);
        bit          et;
        logic [11:0] etg;
        @(negedge clk);
        call_i = c; ret_i = r; loop_begin_i = b; loop_end_i = e;
        next_addr_i = na; loop_count_i = cn;
        #1;
        et = exp_taken_f(c, r, b, e);
        chk(taken_o == et, tag, "taken", taken_o, et);
        if (et) begin
            etg = exp_target_f(c, r);
            chk(target_o == etg, tag, "target", target_o, etg);
            taken_count++;
        end
        // update model
        if (c) begin
            if (m_rn == D) m_ovf = 1; else begin m_rs[m_rn] = na; m_rn++; end
        end else if (r) begin
            if (m_rn == 0) m_unf = 1; else m_rn--;
        end
        if (b) begin
            if (m_ln == D) m_ovf = 1;
            else begin m_la[m_ln] = na; m_lc[m_ln] = cn; m_ln++; end
        end else if (e) begin
            if (m_ln == 0) m_unf = 1;
            else if (m_lc[m_ln-1] != 0) m_lc[m_ln-1] = m_lc[m_ln-1] - 1;
            else m_ln--;
        end
        @(posedge clk);
        #1;
        call_i = 0; ret_i = 0; loop_begin_i = 0; loop_end_i = 0;
        chk(overflow_o == m_ovf, (tag == "R3") ? "R3" : "R10", "overflow flag", overflow_o, m_ovf);
        chk(underflow_o == m_unf, (tag == "R4") ? "R4" : "R10", "underflow flag", underflow_o, m_unf);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_rn = 0; m_ln = 0; m_ovf = 0; m_unf = 0; taken_count = 0;
        do_reset();

        // R2: LIFO call/return
        cyc(1,0,0,0, 12'h010, 0, "R2");
        cyc(1,0,0,0, 12'h020, 0, "R2");
        cyc(1,0,0,0, 12'h030, 0, "R2");
        for (int i = 0; i < 3; i++) cyc(0,1,0,0, 0, 0, "R2");

        // R4: underflow on both stacks, sticky (R10)
        cyc(0,1,0,0, 0, 0, "R4");
        cyc(0,0,0,1, 0, 0, "R4");
        for (int i = 0; i < 3; i++) cyc(0,0,0,0, 0, 0, "R10");
        do_reset();

        // R3: overflow return stack, contents intact
        for (int i = 0; i < D; i++) cyc(1,0,0,0, 12'(12'h200 + i), 0, "R3");
        cyc(1,0,0,0, 12'hFFF, 0, "R3");
        for (int i = 0; i < D; i++) cyc(0,1,0,0, 0, 0, "R3");
        do_reset();
        for (int i = 0; i < D; i++) cyc(0,0,1,0, 12'(12'h300 + i), 12'd0, "R3");
        cyc(0,0,1,0, 12'hABC, 12'd5, "R3");
        for (int i = 0; i < D; i++) cyc(0,0,0,1, 0, 0, "R6");
        do_reset();

        // R5/R6: count N runs body N+1 times
        cyc(0,0,1,0, 12'h100, 12'd2, "R5");
        taken_count = 0;
        for (int i = 0; i < 3; i++) cyc(0,0,0,1, 0, 0, "R5");
        chk(taken_count == 2, "R6", "taken loop-ends for count 2", taken_count, 2);
        cyc(0,0,1,0, 12'h140, 12'd0, "R6");
        taken_count = 0;
        cyc(0,0,0,1, 0, 0, "R6");
        chk(taken_count == 0, "R6", "taken loop-ends for count 0", taken_count, 0);

        // R7: nesting
        cyc(0,0,1,0, 12'h400, 12'd1, "R7");
        cyc(0,0,1,0, 12'h410, 12'd1, "R7");
        for (int i = 0; i < 4; i++) cyc(0,0,0,1, 0, 0, "R7");

        // R8: taken return and taken loop-end together
        cyc(1,0,0,0, 12'h555, 0, "R8");
        cyc(0,0,1,0, 12'h600, 12'd2, "R8");
        cyc(0,1,0,1, 0, 0, "R8");
        cyc(0,0,0,1, 0, 0, "R8");
        cyc(0,0,0,1, 0, 0, "R8");

        // R9: same-group collisions
        cyc(1,1,0,0, 12'h777, 0, "R9");
        cyc(0,1,0,0, 0, 0, "R9");
        cyc(0,0,1,1, 12'h700, 12'd1, "R9");
        cyc(0,0,0,1, 0, 0, "R9");
        cyc(0,0,0,1, 0, 0, "R9");
        do_reset();

        // random mix
        for (int i = 0; i < 5000; i++) begin
            bit c = ($urandom % 5) == 0;
            bit r = ($urandom % 5) == 0;
            bit b = ($urandom % 5) == 0;
            bit e = ($urandom % 3) == 0;
            logic [11:0] na = 12'($urandom);
            logic [11:0] cn = 12'($urandom % 4);
            string tg;
            if ((c && r) || (b && e)) tg = "R9";
            else if ((c || r) && (b || e)) tg = "R8";
            else if (b || e) tg = "R5";
            else tg = "R2";
            cyc(c, r, b, e, na, cn, tg);
            if (i % 1000 == 999) do_reset();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule